// File: doc/BRIEF.md
# Priority status LED pattern generator

This block drives one status LED from a vector of condition flags that are ranked by priority. Each priority level carries a pattern descriptor: steady on, steady off, continuous slow blinking, continuous fast blinking, a count of short flashes followed by a pause, or direct pass-through of a user-controlled bit. The highest-priority flag that is raised picks the pattern shown. When no flag is raised the LED stays dark. Flash counts give a person reading the LED a code: for example, five flashes can mean one power domain failed and three flashes a different one.

Patterns are built on a frame of eight slots. A slot prescaler sets the slot length, so a full frame repeats at roughly 0.7 Hz when the divider is chosen for the system clock. A second prescaler sets the half-period of the fast blink. Small divider values allow short simulations. When the selected priority level changes, the frame starts again at slot 0, so a flash code is always shown from its first flash.

Top module: `led_pattern_gen`

## Requirements
- R1: While reset is asserted, and after it is released with no flag raised, `ledOut` is 0.
- R2: Flag bit i belongs to priority level i. Bit 0 has the highest priority, and the lowest-index eligible raised flag selects the pattern.
- R3: When no flag is eligible, the LED is off. One cycle after all flags are low, `ledOut` is 0.
- R4: `LEVEL_CFG` holds 6 bits per level, with level i at bits [6i+5:6i]. The upper 3 bits give the kind and the lower 3 bits give a flash count. Kind codes are 0 steady off, 1 steady on, 2 slow blink, 3 fast blink, 4 flash code and 5 user pass-through. Codes 6 and 7 behave as off.
- R5: Slow blink lights the LED through slots 0 to 3 of each frame and keeps it dark through slots 4 to 7.
- R6: Fast blink lights the LED for the first `FAST_DIV` cycles after a restart and then toggles it every `FAST_DIV` cycles.
- R7: A flash code with count N lights the LED during the first `SLOT_DIV/2` cycles of each of slots 0 to N-1. The LED is dark for the rest of the frame, so it gives N separate flashes and then a pause.
- R8: A user pass-through level copies `userBit` to `ledOut` combinationally while it is selected. It counts as raised only when `userEn` is 1. Otherwise it is skipped and a lower level can win.
- R9: Each slot lasts `SLOT_DIV` cycles. When the selected level changes, the clock edge that samples the new flags begins cycle 0 of slot 0, and the fast-blink phase restarts at the same edge.
- R10: While the selection stays the same, the 8-slot frame repeats without a gap, so two frames of an N-flash code show 2N flashes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| condFlags | input | NUM_LEVELS | Condition flags; bit 0 is the highest priority |
| userEn | input | 1 | Makes the user pass-through level eligible |
| userBit | input | 1 | User-defined value shown by the pass-through level |
| ledOut | output | 1 | LED drive, 1 = lit |

## Verification
Random flag vectors with sparse set bits and a random enable exercise the priority choice across all eight levels. A frame with the wrong pattern, or from the wrong level, differs from the expected waveform cycle by cycle and also in its flash count. Directed cases cover the following:
- A switch from one flash code to another partway through a frame, which shows whether the frame restarts.
- A user level with the enable off and a lower level raised, which shows whether the disabled level falls through.
- A two-frame flash run, which separates a frame that repeats from one that stalls.
- A random `userBit` stream on the pass-through level, which tests whether `ledOut` follows that bit in every cycle.

// File: rtl/led_pattern_pkg.sv
package led_pattern_pkg;

  localparam int CFG_W   = 6;
  localparam int CNT_W   = 3;
  localparam int KIND_W  = 3;
  localparam int FRAME_SLOTS = 8;
  localparam int SLOT_IDX_W  = $clog2(FRAME_SLOTS);

  typedef enum logic [KIND_W-1:0] {
    PAT_OFF   = 3'd0,
    PAT_ON    = 3'd1,
    PAT_SLOW  = 3'd2,
    PAT_FAST  = 3'd3,
    PAT_FLASH = 3'd4,
    PAT_USER  = 3'd5
  } patKind_e;

  typedef struct packed {
    logic             restart;
    patKind_e         kind;
    logic [CNT_W-1:0] count;
  } patStrobe_t;

endpackage

// File: rtl/led_pattern_ctrl.sv
module led_pattern_ctrl
  import led_pattern_pkg::*;
#(
  parameter int NUM_LEVELS = 8,
  parameter logic [NUM_LEVELS*CFG_W-1:0] LEVEL_CFG = '0
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NUM_LEVELS-1:0] condFlags,
  input  logic                  userEn,
  output patStrobe_t            strb
);

  localparam int LVL_W = $clog2(NUM_LEVELS + 1);
  localparam logic [LVL_W-1:0] LVL_NONE = LVL_W'(NUM_LEVELS);

  patKind_e         lvlKind  [NUM_LEVELS];
  logic [CNT_W-1:0] lvlCount [NUM_LEVELS];
  logic [NUM_LEVELS-1:0] eligible;

  for (genvar g = 0; g < NUM_LEVELS; g++) begin : gLevel
    assign lvlKind[g]  = patKind_e'(LEVEL_CFG[g*CFG_W+CNT_W +: KIND_W]);
    assign lvlCount[g] = LEVEL_CFG[g*CFG_W +: CNT_W];
    assign eligible[g] = condFlags[g] && ((lvlKind[g] != PAT_USER) || userEn);
  end

  logic [LVL_W-1:0] lvlNext, lvlCur;
  patKind_e         kindNext, kindCur;
  logic [CNT_W-1:0] cntNext, cntCur;

  // lowest index wins: scan from the bottom so the last hit overrides
  always_comb begin
    lvlNext  = LVL_NONE;
    kindNext = PAT_OFF;
    cntNext  = '0;
    for (int i = NUM_LEVELS - 1; i >= 0; i--) begin
      if (eligible[i]) begin
        lvlNext  = LVL_W'(i);
        kindNext = lvlKind[i];
        cntNext  = lvlCount[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lvlCur  <= LVL_NONE;
      kindCur <= PAT_OFF;
      cntCur  <= '0;
    end else begin
      lvlCur  <= lvlNext;
      kindCur <= kindNext;
      cntCur  <= cntNext;
    end
  end

  always_comb begin
    strb.restart = (lvlNext != lvlCur);
    strb.kind    = kindCur;
    strb.count   = cntCur;
  end

endmodule

// File: rtl/led_pattern_dp.sv
module led_pattern_dp
  import led_pattern_pkg::*;
#(
  parameter int SLOT_DIV = 22321429,
  parameter int FAST_DIV = 11160714,
  localparam int SLOT_W = (SLOT_DIV > 1) ? $clog2(SLOT_DIV) : 1,
  localparam int FAST_W = (FAST_DIV > 1) ? $clog2(FAST_DIV) : 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  patStrobe_t            strb,
  input  logic                  userBit,
  output logic [SLOT_IDX_W-1:0] slotIdx,
  output logic [SLOT_W-1:0]     divCnt,
  output logic                  ledOut
);

  localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(SLOT_DIV - 1);
  localparam logic [SLOT_W-1:0] SLOT_HALF = SLOT_W'(SLOT_DIV / 2);
  localparam logic [FAST_W-1:0] FAST_LAST = FAST_W'(FAST_DIV - 1);
  localparam int SLOW_LIT_SLOTS = FRAME_SLOTS / 2;

  logic [FAST_W-1:0] fastCnt;
  logic              fastPhase;

  always_ff @(posedge clk) begin
    if (rst || strb.restart) begin
      divCnt  <= '0;
      slotIdx <= '0;
    end else if (divCnt == SLOT_LAST) begin
      divCnt  <= '0;
      slotIdx <= SLOT_IDX_W'(slotIdx + 1'b1);
    end else begin
      divCnt  <= SLOT_W'(divCnt + 1'b1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst || strb.restart) begin
      fastCnt   <= '0;
      fastPhase <= 1'b0;
    end else if (fastCnt == FAST_LAST) begin
      fastCnt   <= '0;
      fastPhase <= ~fastPhase;
    end else begin
      fastCnt   <= FAST_W'(fastCnt + 1'b1);
    end
  end

  always_comb begin
    unique case (strb.kind)
      PAT_ON:    ledOut = 1'b1;
      PAT_SLOW:  ledOut = (32'(slotIdx) < SLOW_LIT_SLOTS);
      PAT_FAST:  ledOut = ~fastPhase;
      PAT_FLASH: ledOut = (32'(slotIdx) < 32'(strb.count)) && (divCnt < SLOT_HALF);
      PAT_USER:  ledOut = userBit;
      default:   ledOut = 1'b0;
    endcase
  end

endmodule

// File: rtl/led_pattern_gen.sv
module led_pattern_gen
  import led_pattern_pkg::*;
#(
  parameter int NUM_LEVELS = 8,
  parameter logic [NUM_LEVELS*CFG_W-1:0] LEVEL_CFG = 48'o41_10_50_20_43_44_45_30,
  parameter int SLOT_DIV = 22321429,
  parameter int FAST_DIV = 11160714
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NUM_LEVELS-1:0] condFlags,
  input  logic                  userEn,
  input  logic                  userBit,
  output logic                  ledOut
);

  localparam int SLOT_W = (SLOT_DIV > 1) ? $clog2(SLOT_DIV) : 1;

  patStrobe_t            ctrlStrb;
  logic [SLOT_IDX_W-1:0] slotIdx;
  logic [SLOT_W-1:0]     divCnt;

  led_pattern_ctrl #(
    .NUM_LEVELS(NUM_LEVELS),
    .LEVEL_CFG (LEVEL_CFG)
  ) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .condFlags(condFlags),
    .userEn   (userEn),
    .strb     (ctrlStrb)
  );

  led_pattern_dp #(
    .SLOT_DIV(SLOT_DIV),
    .FAST_DIV(FAST_DIV)
  ) u_dp (
    .clk    (clk),
    .rst    (rst),
    .strb   (ctrlStrb),
    .userBit(userBit),
    .slotIdx(slotIdx),
    .divCnt (divCnt),
    .ledOut (ledOut)
  );

endmodule

// File: rtl/led_pattern_chk.sv
module led_pattern_chk
  import led_pattern_pkg::*;
#(
  parameter int NUM_LEVELS = 8,
  parameter int SLOT_W = 3
) (
  input logic                  clk,
  input logic                  rst,
  input logic [NUM_LEVELS-1:0] condFlags,
  input logic                  userBit,
  input logic                  ledOut,
  input patStrobe_t            ctrlStrb,
  input logic [SLOT_IDX_W-1:0] slotIdx,
  input logic [SLOT_W-1:0]     divCnt
);

  AST_IDLE_DARK: assert property (@(posedge clk) disable iff (rst)
    (condFlags == '0) |=> !ledOut); // R3

  AST_STEADY_ON: assert property (@(posedge clk) disable iff (rst)
    (ctrlStrb.kind == PAT_ON) |-> ledOut); // R4

  AST_STEADY_OFF: assert property (@(posedge clk) disable iff (rst)
    (ctrlStrb.kind == PAT_OFF) |-> !ledOut); // R4

  AST_SLOW_DARK_HALF: assert property (@(posedge clk) disable iff (rst)
    ((ctrlStrb.kind == PAT_SLOW) && (slotIdx >= 3'd4)) |-> !ledOut); // R5

  AST_FLASH_PAUSE: assert property (@(posedge clk) disable iff (rst)
    ((ctrlStrb.kind == PAT_FLASH) && (slotIdx >= ctrlStrb.count)) |-> !ledOut); // R7

  AST_USER_FOLLOW: assert property (@(posedge clk) disable iff (rst)
    (ctrlStrb.kind == PAT_USER) |-> (ledOut == userBit)); // R8

  AST_RESTART_SLOT0: assert property (@(posedge clk) disable iff (rst)
    ctrlStrb.restart |=> ((slotIdx == '0) && (divCnt == '0))); // R9

endmodule

bind led_pattern_gen led_pattern_chk #(
  .NUM_LEVELS(NUM_LEVELS),
  .SLOT_W    (SLOT_W)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .condFlags(condFlags),
  .userBit  (userBit),
  .ledOut   (ledOut),
  .ctrlStrb (ctrlStrb),
  .slotIdx  (slotIdx),
  .divCnt   (divCnt)
);

// File: tb/led_pattern_gen_bench.sv
module led_pattern_gen_bench;

  localparam int S = 8;
  localparam int F = 4;
  localparam int FRAME = 8 * S;
  localparam logic [47:0] CFG = 48'o41_10_50_20_43_44_45_30;
  localparam int WD_CYCLES = 150000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] condFlags = '0;
  logic       userEn = 1'b0;
  logic       userBit = 1'b0;
  logic       ledOut;

  int totalCnt = 0;
  int failCnt  = 0;
  bit done     = 1'b0;

  always #4 clk = ~clk;

  led_pattern_gen #(
    .NUM_LEVELS(8),
    .LEVEL_CFG (CFG),
    .SLOT_DIV  (S),
    .FAST_DIV  (F)
  ) u_led_pattern_gen (
    .clk      (clk),
    .rst      (rst),
    .condFlags(condFlags),
    .userEn   (userEn),
    .userBit  (userBit),
    .ledOut   (ledOut)
  );

  function automatic int kindOf(int lvl);
    return int'(CFG[lvl*6+3 +: 3]);
  endfunction

  function automatic int countOf(int lvl);
    return int'(CFG[lvl*6 +: 3]);
  endfunction

  function automatic int pickLevel(logic [7:0] f, bit en);
    for (int i = 0; i < 8; i++)
      if (f[i] && (kindOf(i) != 5 || en)) return i;
    return -1;
  endfunction

  function automatic bit expectLed(int kind, int cnt, int c, bit ub);
    int slot = (c / S) % 8;
    int d = c % S;
    case (kind)
      1: return 1'b1;
      2: return slot < 4;
      3: return ((c / F) % 2) == 0;
      4: return (slot < cnt) && (d < S / 2);
      5: return ub;
      default: return 1'b0;
    endcase
  endfunction

  function automatic int expectPulses(int kind, int cnt, int n, bit ub);
    case (kind)
      1: return 1;
      2: return n / FRAME;
      3: return n / (2 * F);
      4: return cnt * (n / FRAME);
      5: return ub ? 1 : 0;
      default: return 0;
    endcase
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    totalCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic printSummary();
    $display("%0d/%0d checks passed", totalCnt - failCnt, totalCnt);
  endtask

  task automatic apply(logic [7:0] f, bit en);
    condFlags = f;
    userEn = en;
  endtask

  // measure n cycles of the frame beginning at the edge after apply()
  task automatic measure(int n, int lvl, string req);
    int kind = (lvl < 0) ? 0 : kindOf(lvl);
    int cnt  = (lvl < 0) ? 0 : countOf(lvl);
    int mism = 0;
    int firstBad = -1;
    int pulses = 0;
    bit prev = 1'b0;
    for (int c = 0; c < n; c++) begin
      @(negedge clk);
      if (ledOut !== expectLed(kind, cnt, c, userBit)) begin
        mism++;
        if (firstBad < 0) firstBad = c;
      end
      if (ledOut && !prev) pulses++;
      prev = ledOut;
    end
    check(mism == 0, req, $sformatf("waveform level %0d, mismatching cycles (first at %0d)", lvl, firstBad), mism, 0);
    check(pulses == expectPulses(kind, cnt, n, userBit), req,
          $sformatf("pulse count level %0d", lvl), pulses, expectPulses(kind, cnt, n, userBit));
  endtask

  initial begin
    #(WD_CYCLES * 8);
    if (!done) begin
      totalCnt++;
      failCnt++;
      $display("FAIL watchdog: actual %0d expected %0d cycles max", WD_CYCLES, WD_CYCLES);
      printSummary();
      $finish;
    end
  end

  initial begin
    int mism;
    void'($urandom(32'd5150));
    // R1: dark during reset
    repeat (3) @(negedge clk);
    check(ledOut === 1'b0, "R1", "led during reset", int'(ledOut), 0);
    rst = 1'b0;
    mism = 0;
    for (int c = 0; c < FRAME; c++) begin
      @(negedge clk);
      if (ledOut !== 1'b0) mism++;
    end
    check(mism == 0, "R1", "lit cycles after reset with no flag", mism, 0);

    // R7 flash codes 5,4,3,1 and R6 fast, R5 slow, R4 steady on
    apply(8'b0000_0010, 1'b0); measure(FRAME, 1, "R7");
    apply(8'b0000_0100, 1'b0); measure(FRAME, 2, "R7");
    apply(8'b0000_1000, 1'b0); measure(FRAME, 3, "R7");
    apply(8'b1000_0000, 1'b0); measure(FRAME, 7, "R7");
    apply(8'b0000_0001, 1'b0); measure(FRAME, 0, "R6");
    apply(8'b0001_0000, 1'b0); measure(FRAME, 4, "R5");
    apply(8'b0100_0000, 1'b0); measure(FRAME, 6, "R4");

    // R2: several raised flags, highest priority must win
    apply(8'b1101_1100, 1'b1); measure(FRAME, 2, "R2");

    // R10: two back-to-back frames of a 4-flash code
    apply(8'b0000_0100, 1'b0); measure(2 * FRAME, 2, "R10");
    apply(8'b0000_1000, 1'b0); measure(2 * FRAME, 3, "R10");

    // R9: switch from 3 flashes to 5 flashes partway through a frame
    apply(8'b0000_1000, 1'b0);
    repeat (20) @(negedge clk);
    apply(8'b0000_0010, 1'b0); measure(FRAME, 1, "R9");

    // R8: disabled user level falls through to steady on (userBit held 1)
    userBit = 1'b1;
    apply(8'b0110_0000, 1'b0); measure(FRAME, 6, "R8");
    // R8: disabled user level alone -> off
    apply(8'b0010_0000, 1'b0); measure(FRAME, -1, "R8");
    // R8: enabled user level follows a random userBit stream
    apply(8'b0110_0000, 1'b1);
    @(negedge clk);
    mism = 0;
    for (int c = 0; c < FRAME; c++) begin
      userBit = 1'($urandom);
      #1;
      if (ledOut !== userBit) mism++;
      @(negedge clk);
    end
    check(mism == 0, "R8", "cycles where led differs from userBit", mism, 0);
    userBit = 1'b0;

    // R3: all flags low -> dark
    apply(8'b0000_0000, 1'b0); measure(FRAME, -1, "R3");

    // R2: random flag sets with sparse bits
    for (int k = 0; k < 40; k++) begin
      logic [7:0] f = 8'($urandom & $urandom);
      bit en = 1'($urandom);
      userBit = 1'($urandom);
      apply(f, en);
      measure(FRAME, pickLevel(f, en), "R2");
    end

    done = 1'b1;
    printSummary();
    $finish;
  end

endmodule